// File: doc/BRIEF.md
# NMI Vector Redirection Unit

This unit sits on the cartridge side of the CPU bus and watches the two-byte fetch of the non-maskable interrupt vector. When armed, it overrides the data bus during that fetch so the CPU jumps to a cartridge-supplied hook routine instead of the game's own handler. The hook can do its work, such as polling the controller for a save hotkey, and then jump onward to the game's real handler. Reset-vector handling is not part of this unit.

The game's original vector is learned in one of two ways. It is captured from memory while the unit is unarmed, or it is written byte by byte through a small configuration port. Either way it can be read back by the hook at two fixed readback addresses. Arming and disarming are sampled only between vector fetches. Both bytes of one fetch therefore always come from the same source and from the same latched hook address.

The sequencer has four states. `ST_PASS` means unarmed, with no fetch in progress. `ST_PASS_LO` means unarmed, with the low byte already fetched and captured. `ST_ARMED` means armed, with no fetch in progress. `ST_ARMED_LO` means armed, with the low byte already substituted. A bus cycle ends on the falling edge of M2. The transitions are:
- `ST_PASS` goes to `ST_PASS_LO` when a read of $FFFA ends (capture low byte).
- `ST_PASS` goes to `ST_ARMED` when the arm request is high.
- `ST_PASS_LO` goes back to `ST_PASS` when any cycle ends. The vector is committed if that cycle was a read of $FFFB; otherwise the pair is abandoned.
- `ST_ARMED` goes to `ST_ARMED_LO` when a read of $FFFA ends.
- `ST_ARMED` goes to `ST_PASS` when the arm request is low.
- `ST_ARMED_LO` goes back to `ST_ARMED` when any cycle ends. The hook pulse fires if that cycle was a read of $FFFB.

Top module: `nmi_redirect`

## Requirements
- R1: A read of any address other than $FFFA, $FFFB, $5FF8 or $5FF9 never enables the override (`ovr_en` stays 0), armed or not.
- R2: While armed, a read of $FFFA drives the hook address bits 7:0 and a read of $FFFB drives bits 15:8.
- R3: While unarmed, vector reads are not overridden. A completed read of $FFFA followed directly by a read of $FFFB stores the two data-bus bytes as the original vector (low byte, then high byte). A pair broken by any other bus cycle stores nothing, and reads made while armed store nothing.
- R4: In every state, a read of $5FF8 drives the stored original vector bits 7:0 and a read of $5FF9 drives bits 15:8.
- R5: `hook_entered` goes high for exactly one clock, in the clock after a substituted $FFFB read ends, and only when that read followed a substituted $FFFA read.
- R6: A change of `arm_req` made between the two reads of a vector fetch takes effect only after the pair ends. Both bytes come from one source.
- R7: A pulse on `cfg_we` loads `cfg_byte` into the original vector high byte when `cfg_hi` is 1 and into the low byte when it is 0. The other byte is left unchanged.
- R8: `ovr_en` is high only while `bus_m2` is high and `bus_rw` is 1 (read). Write cycles to the vector or readback addresses are never driven.
- R9: After reset the unit is unarmed, the stored original vector is $0000, and `ovr_en` and `hook_entered` are 0.
- R10: The hook address is latched at the start of an armed fetch. A change of `hook_addr` between the two reads does not split the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than M2 |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | CPU address bus |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_m2 | input | 1 | CPU phase-2 clock; data phase while high |
| bus_din | input | DW | Data bus value seen from memory |
| arm_req | input | 1 | Level request to redirect the vector |
| hook_addr | input | 2*DW | Entry address of the hook routine |
| cfg_we | input | 1 | One-clock write strobe for the stored vector |
| cfg_hi | input | 1 | Selects the high (1) or low (0) stored byte |
| cfg_byte | input | DW | Byte written by `cfg_we` |
| ovr_data | output | DW | Value to drive onto the data bus |
| ovr_en | output | 1 | Data-bus drive enable |
| hook_entered | output | 1 | One-clock pulse on entry to the hook |

## Verification
The assertions assume that the bus inputs are synchronous to `clk` and stay stable for at least one clock on each side of an M2 edge. They also assume that `bus_addr` and `bus_rw` do not change while M2 is high. The bench drives every bus cycle through one task that holds the address through the whole high phase and through one low clock after it. It changes `arm_req`, `hook_addr` and the configuration port only while M2 is low, with at least one idle clock before the next rising edge. Within those limits the behavioural model predicts the enable, the data and the pulse for every clock.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

    typedef enum logic [1:0] {
        ST_PASS     = 2'd0,
        ST_PASS_LO  = 2'd1,
        ST_ARMED    = 2'd2,
        ST_ARMED_LO = 2'd3
    } nvr_state_e;

    function automatic logic is_armed(input nvr_state_e s);
        return (s == ST_ARMED) || (s == ST_ARMED_LO);
    endfunction

endpackage

// File: rtl/nvr_bus_sampler.sv
module nvr_bus_sampler #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rw,
    input  logic          bus_m2,
    input  logic [DW-1:0] bus_din,
    output logic [AW-1:0] addr_q,
    output logic          rw_q,
    output logic [DW-1:0] din_q,
    output logic          cyc_end
);

    logic m2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rw_q   <= 1'b1;
            din_q  <= '0;
            m2_q   <= 1'b0;
        end else begin
            addr_q <= bus_addr;
            rw_q   <= bus_rw;
            din_q  <= bus_din;
            m2_q   <= bus_m2;
        end
    end

    // A bus cycle ends when M2 falls; the registered copies still hold its values.
    assign cyc_end = m2_q & ~bus_m2;

endmodule

// File: rtl/nvr_seq.sv
module nvr_seq
    import nvr_pkg::*;
#(
    parameter int             AW     = 16,
    parameter logic [AW-1:0]  VEC_LO = 16'hFFFA
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_end,
    input  logic [AW-1:0] addr_q,
    input  logic          rw_q,
    input  logic          arm_req,
    output nvr_state_e    state,
    output logic          lo_capture,
    output logic          pair_commit,
    output logic          hook_hold,
    output logic          hook_pulse
);

    localparam logic [AW-1:0] VEC_HI = VEC_LO + AW'(1);

    nvr_state_e nxt;
    logic       rd_lo;
    logic       rd_hi;
    logic       hook_fire;

    assign rd_lo = cyc_end && rw_q && (addr_q == VEC_LO);
    assign rd_hi = cyc_end && rw_q && (addr_q == VEC_HI);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_PASS;
        else     state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_PASS: begin
                if (rd_lo)        nxt = ST_PASS_LO;
                else if (arm_req) nxt = ST_ARMED;
            end
            ST_PASS_LO: begin
                if (cyc_end) nxt = ST_PASS;
            end
            ST_ARMED: begin
                if (rd_lo)         nxt = ST_ARMED_LO;
                else if (!arm_req) nxt = ST_PASS;
            end
            ST_ARMED_LO: begin
                if (cyc_end) nxt = ST_ARMED;
            end
            default: nxt = ST_PASS;
        endcase
    end

    // Outputs
    always_comb begin
        lo_capture  = 1'b0;
        pair_commit = 1'b0;
        hook_fire   = 1'b0;
        hook_hold   = 1'b0;
        unique case (state)
            ST_PASS:     lo_capture  = rd_lo;
            ST_PASS_LO:  pair_commit = rd_hi;
            ST_ARMED:    ;
            ST_ARMED_LO: begin
                hook_fire = rd_hi;
                hook_hold = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) hook_pulse <= 1'b0;
        else     hook_pulse <= hook_fire;
    end

endmodule

// File: rtl/nvr_vector_store.sv
module nvr_vector_store #(
    parameter int DW = 8,
    localparam int VW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din_q,
    input  logic          lo_capture,
    input  logic          pair_commit,
    input  logic          cfg_we,
    input  logic          cfg_hi,
    input  logic [DW-1:0] cfg_byte,
    input  logic [VW-1:0] hook_addr,
    input  logic          hook_hold,
    output logic [VW-1:0] orig_vec,
    output logic [VW-1:0] hook_vec
);

    logic [DW-1:0] cap_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_lo   <= '0;
            orig_vec <= '0;
        end else begin
            if (lo_capture)  cap_lo   <= din_q;
            if (pair_commit) orig_vec <= {din_q, cap_lo};
            if (cfg_we) begin
                if (cfg_hi) orig_vec[VW-1:DW] <= cfg_byte;
                else        orig_vec[DW-1:0]  <= cfg_byte;
            end
        end
    end

    // The hook address follows its input except in the middle of an armed pair.
    always_ff @(posedge clk) begin
        if (rst)             hook_vec <= '0;
        else if (!hook_hold) hook_vec <= hook_addr;
    end

endmodule

// File: rtl/nvr_drive.sv
module nvr_drive
    import nvr_pkg::*;
#(
    parameter int            AW     = 16,
    parameter int            DW     = 8,
    parameter logic [AW-1:0] VEC_LO = 16'hFFFA,
    parameter logic [AW-1:0] RB_LO  = 16'h5FF8,
    localparam int VW = 2 * DW,
    localparam int NB = VW / DW
) (
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rw,
    input  logic          bus_m2,
    input  nvr_state_e    state,
    input  logic [VW-1:0] orig_vec,
    input  logic [VW-1:0] hook_vec,
    output logic [DW-1:0] ovr_data,
    output logic          ovr_en
);

    logic [NB-1:0] vec_hit;
    logic [NB-1:0] rb_hit;
    logic [DW-1:0] hook_byte [NB];
    logic [DW-1:0] orig_byte [NB];
    logic          armed;

    assign armed = is_armed(state);

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign vec_hit[b]   = (bus_addr == VEC_LO + AW'(b));
        assign rb_hit[b]    = (bus_addr == RB_LO + AW'(b));
        assign hook_byte[b] = hook_vec[b*DW +: DW];
        assign orig_byte[b] = orig_vec[b*DW +: DW];
    end

    always_comb begin
        ovr_en   = 1'b0;
        ovr_data = '0;
        if (bus_m2 && bus_rw) begin
            for (int b = 0; b < NB; b++) begin
                if (armed && vec_hit[b]) begin
                    ovr_en   = 1'b1;
                    ovr_data = hook_byte[b];
                end else if (rb_hit[b]) begin
                    ovr_en   = 1'b1;
                    ovr_data = orig_byte[b];
                end
            end
        end
    end

endmodule

// File: rtl/nmi_redirect.sv
module nmi_redirect
    import nvr_pkg::*;
#(
    parameter int            AW     = 16,
    parameter int            DW     = 8,
    parameter logic [AW-1:0] VEC_LO = 16'hFFFA,
    parameter logic [AW-1:0] RB_LO  = 16'h5FF8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rw,
    input  logic            bus_m2,
    input  logic [DW-1:0]   bus_din,
    input  logic            arm_req,
    input  logic [2*DW-1:0] hook_addr,
    input  logic            cfg_we,
    input  logic            cfg_hi,
    input  logic [DW-1:0]   cfg_byte,
    output logic [DW-1:0]   ovr_data,
    output logic            ovr_en,
    output logic            hook_entered
);

    localparam int VW = 2 * DW;

    logic [AW-1:0] addr_q;
    logic          rw_q;
    logic [DW-1:0] din_q;
    logic          cyc_end;
    nvr_state_e    fsm_state;
    logic          lo_capture;
    logic          pair_commit;
    logic          hook_hold;
    logic [VW-1:0] orig_vec;
    logic [VW-1:0] hook_vec;

    nvr_bus_sampler #(.AW(AW), .DW(DW)) u_smp (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_m2(bus_m2), .bus_din(bus_din),
        .addr_q(addr_q), .rw_q(rw_q), .din_q(din_q), .cyc_end(cyc_end)
    );

    nvr_seq #(.AW(AW), .VEC_LO(VEC_LO)) u_seq (
        .clk(clk), .rst(rst),
        .cyc_end(cyc_end), .addr_q(addr_q), .rw_q(rw_q), .arm_req(arm_req),
        .state(fsm_state), .lo_capture(lo_capture), .pair_commit(pair_commit),
        .hook_hold(hook_hold), .hook_pulse(hook_entered)
    );

    nvr_vector_store #(.DW(DW)) u_store (
        .clk(clk), .rst(rst),
        .din_q(din_q), .lo_capture(lo_capture), .pair_commit(pair_commit),
        .cfg_we(cfg_we), .cfg_hi(cfg_hi), .cfg_byte(cfg_byte),
        .hook_addr(hook_addr), .hook_hold(hook_hold),
        .orig_vec(orig_vec), .hook_vec(hook_vec)
    );

    nvr_drive #(.AW(AW), .DW(DW), .VEC_LO(VEC_LO), .RB_LO(RB_LO)) u_drv (
        .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_m2(bus_m2),
        .state(fsm_state), .orig_vec(orig_vec), .hook_vec(hook_vec),
        .ovr_data(ovr_data), .ovr_en(ovr_en)
    );

endmodule

// File: rtl/nvr_checker.sv
module nvr_checker
    import nvr_pkg::*;
#(
    parameter int            AW     = 16,
    parameter int            DW     = 8,
    parameter logic [AW-1:0] VEC_LO = 16'hFFFA,
    parameter logic [AW-1:0] RB_LO  = 16'h5FF8
) (
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_rw,
    input logic            bus_m2,
    input logic            ovr_en,
    input logic            hook_entered,
    input logic            cfg_we,
    input nvr_state_e      state,
    input logic [2*DW-1:0] orig_vec
);

    AST_DRIVE_READ_PHASE: assert property (@(posedge clk) disable iff (rst)
        ovr_en |-> (bus_m2 && bus_rw)); // R8

    AST_DRIVE_ADDR_SET: assert property (@(posedge clk) disable iff (rst)
        ovr_en |-> (bus_addr == VEC_LO || bus_addr == VEC_LO + AW'(1) ||
                    bus_addr == RB_LO  || bus_addr == RB_LO + AW'(1))); // R1

    AST_HOOK_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        hook_entered |=> !hook_entered); // R5

    AST_HOOK_AFTER_PAIR: assert property (@(posedge clk) disable iff (rst)
        hook_entered |-> ($past(state) == ST_ARMED_LO)); // R5

    AST_ARMED_PAIR_KEPT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED_LO) |=> (state == ST_ARMED || state == ST_ARMED_LO)); // R6

    AST_PASS_PAIR_KEPT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PASS_LO) |=> (state == ST_PASS || state == ST_PASS_LO)); // R6

    AST_ARMED_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (is_armed(state) && !cfg_we) |=> $stable(orig_vec)); // R3

endmodule

bind nmi_redirect nvr_checker #(.AW(AW), .DW(DW), .VEC_LO(VEC_LO), .RB_LO(RB_LO)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_m2(bus_m2),
    .ovr_en(ovr_en), .hook_entered(hook_entered), .cfg_we(cfg_we),
    .state(fsm_state), .orig_vec(orig_vec)
);

// File: tb/tb_nmi_redirect.sv
`timescale 1ns/1ps
module tb_nmi_redirect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_rw = 1'b1;
    logic        bus_m2 = 1'b0;
    logic [7:0]  bus_din = 8'h00;
    logic        arm_req = 1'b0;
    logic [15:0] hook_addr = 16'h0000;
    logic        cfg_we = 1'b0;
    logic        cfg_hi = 1'b0;
    logic [7:0]  cfg_byte = 8'h00;
    logic [7:0]  ovr_data;
    logic        ovr_en;
    logic        hook_entered;

    always #4 clk = ~clk;

    nmi_redirect dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_m2(bus_m2),
        .bus_din(bus_din), .arm_req(arm_req), .hook_addr(hook_addr),
        .cfg_we(cfg_we), .cfg_hi(cfg_hi), .cfg_byte(cfg_byte),
        .ovr_data(ovr_data), .ovr_en(ovr_en), .hook_entered(hook_entered)
    );

    // Behavioural reference model
    bit          m_armed = 0;
    bit          m_pend = 0;
    bit          m_pair_armed = 0;
    logic [7:0]  m_cap = 8'h00;
    logic [15:0] m_orig = 16'h0000;
    logic [15:0] m_hook = 16'h0000;
    logic        exp_en = 1'b0;
    logic [7:0]  exp_data = 8'h00;
    logic        exp_pulse = 1'b0;
    logic        smp_en, smp_pulse;
    logic [7:0]  smp_data;
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the rising edge
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            chk("R8 R1 per-clock enable", {15'd0, ovr_en}, {15'd0, exp_en});
            if (exp_en) chk("R2 R4 per-clock data", {8'd0, ovr_data}, {8'd0, exp_data});
            chk("R5 per-clock pulse", {15'd0, hook_entered}, {15'd0, exp_pulse});
        end
    end

    task automatic bus_cycle(input logic [15:0] a, input logic r, input logic [7:0] d);
        bit fire;
        bit sub;
        @(negedge clk);
        bus_addr = a; bus_rw = r; bus_din = d; bus_m2 = 1'b0;
        exp_en = 1'b0; exp_pulse = 1'b0;
        if (!m_pend) begin
            m_armed = arm_req;
            m_hook  = hook_addr;
        end
        @(negedge clk);
        bus_m2 = 1'b1;
        sub = m_pend ? m_pair_armed : m_armed;
        exp_en = 1'b0; exp_data = 8'h00;
        if (r) begin
            if (sub && a == 16'hFFFA)      begin exp_en = 1'b1; exp_data = m_hook[7:0];  end
            else if (sub && a == 16'hFFFB) begin exp_en = 1'b1; exp_data = m_hook[15:8]; end
            else if (a == 16'h5FF8)        begin exp_en = 1'b1; exp_data = m_orig[7:0];  end
            else if (a == 16'h5FF9)        begin exp_en = 1'b1; exp_data = m_orig[15:8]; end
        end
        @(negedge clk);
        #1 smp_en = ovr_en; smp_data = ovr_data;
        @(negedge clk);
        bus_m2 = 1'b0; exp_en = 1'b0;
        fire = 0;
        if (m_pend) begin
            if (r && a == 16'hFFFB) begin
                if (m_pair_armed) fire = 1;
                else m_orig = {d, m_cap};
            end
            m_pend = 0;
        end else if (r && a == 16'hFFFA) begin
            m_pend = 1; m_pair_armed = m_armed; m_cap = d;
        end
        @(negedge clk);
        exp_pulse = fire;
        #1 smp_pulse = hook_entered;
        @(negedge clk);
        exp_pulse = 1'b0;
    endtask

    task automatic cfg_write(input logic hi, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_hi = hi; cfg_byte = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (hi) m_orig[15:8] = v; else m_orig[7:0] = v;
    endtask

    task automatic read_expect(input logic [15:0] a, input logic [7:0] d,
                               input logic en, input logic [7:0] v, input string req);
        bus_cycle(a, 1'b1, d);
        chk(req, {15'd0, smp_en}, {15'd0, en});
        if (en) chk(req, {8'd0, smp_data}, {8'd0, v});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R9 reset enable", {15'd0, ovr_en}, 16'd0);
        chk("R9 reset pulse", {15'd0, hook_entered}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        read_expect(16'h5FF8, 8'hEE, 1'b1, 8'h00, "R9 R4 stored low after reset");
        read_expect(16'h5FF9, 8'hEE, 1'b1, 8'h00, "R9 R4 stored high after reset");
        read_expect(16'h8000, 8'h11, 1'b0, 8'h00, "R1 unarmed plain read");

        // R3 unarmed capture
        read_expect(16'hFFFA, 8'h34, 1'b0, 8'h00, "R3 unarmed low not driven");
        read_expect(16'hFFFB, 8'h12, 1'b0, 8'h00, "R3 unarmed high not driven");
        read_expect(16'h5FF8, 8'h00, 1'b1, 8'h34, "R3 R4 captured low");
        read_expect(16'h5FF9, 8'h00, 1'b1, 8'h12, "R3 R4 captured high");

        // R2 / R5 armed substitution
        arm_req = 1'b1; hook_addr = 16'hC123;
        read_expect(16'hFFFA, 8'hAA, 1'b1, 8'h23, "R2 armed low byte");
        read_expect(16'hFFFB, 8'hBB, 1'b1, 8'hC1, "R2 armed high byte");
        chk("R5 hook pulse after pair", {15'd0, smp_pulse}, 16'd1);
        read_expect(16'h5FF8, 8'h00, 1'b1, 8'h34, "R3 armed pair not captured");
        read_expect(16'h8000, 8'h00, 1'b0, 8'h00, "R1 armed plain read");
        read_expect(16'hFFFB, 8'h00, 1'b1, 8'hC1, "R2 lone high byte");
        chk("R5 no pulse without low read", {15'd0, smp_pulse}, 16'd0);

        // R10 hook change inside a pair
        read_expect(16'hFFFA, 8'h00, 1'b1, 8'h23, "R10 low from old hook");
        hook_addr = 16'hD456;
        read_expect(16'hFFFB, 8'h00, 1'b1, 8'hC1, "R10 high from same hook");
        read_expect(16'hFFFA, 8'h00, 1'b1, 8'h56, "R10 new hook low");
        read_expect(16'hFFFB, 8'h00, 1'b1, 8'hD4, "R10 new hook high");

        // R8 write cycles
        bus_cycle(16'hFFFA, 1'b0, 8'h99);
        chk("R8 write not driven", {15'd0, smp_en}, 16'd0);
        bus_cycle(16'h5FF8, 1'b0, 8'h99);
        chk("R8 readback write not driven", {15'd0, smp_en}, 16'd0);

        // R6 disarm inside an armed pair
        read_expect(16'hFFFA, 8'h00, 1'b1, 8'h56, "R6 armed low");
        arm_req = 1'b0;
        read_expect(16'hFFFB, 8'h00, 1'b1, 8'hD4, "R6 disarm deferred");
        chk("R6 pulse on deferred pair", {15'd0, smp_pulse}, 16'd1);
        read_expect(16'hFFFA, 8'h78, 1'b0, 8'h00, "R6 disarmed low");
        arm_req = 1'b1;
        read_expect(16'hFFFB, 8'h9A, 1'b0, 8'h00, "R6 arm deferred");
        read_expect(16'h5FF9, 8'h00, 1'b1, 8'h9A, "R6 R3 unarmed pair captured");
        read_expect(16'hFFFA, 8'h00, 1'b1, 8'h56, "R6 arm effective after pair");
        read_expect(16'hFFFB, 8'h00, 1'b1, 8'hD4, "R6 arm effective high");
        arm_req = 1'b0;

        // R3 broken pair
        read_expect(16'hFFFA, 8'h11, 1'b0, 8'h00, "R3 broken pair low");
        read_expect(16'h8000, 8'h00, 1'b0, 8'h00, "R1 intervening read");
        read_expect(16'hFFFB, 8'h22, 1'b0, 8'h00, "R3 broken pair high");
        read_expect(16'h5FF8, 8'h00, 1'b1, 8'h78, "R3 broken pair kept low");
        read_expect(16'h5FF9, 8'h00, 1'b1, 8'h9A, "R3 broken pair kept high");

        // R7 configuration port
        cfg_write(1'b0, 8'h5A);
        read_expect(16'h5FF8, 8'h00, 1'b1, 8'h5A, "R7 config low");
        read_expect(16'h5FF9, 8'h00, 1'b1, 8'h9A, "R7 high untouched");
        cfg_write(1'b1, 8'hE7);
        read_expect(16'h5FF9, 8'h00, 1'b1, 8'hE7, "R7 config high");
        read_expect(16'h5FF8, 8'h00, 1'b1, 8'h5A, "R7 low untouched");

        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule